// File: doc/BRIEF.md
# Cross-Bridge Exclusive-Access Lock Tracker

This block sits inside a two-port bus-to-bus bridge and decides what happens to exclusive-access (bus lock) requests. It watches the upstream (primary) side for a transaction start, the active-low lock line, the bus-idle flag and the command code. It sorts each request aimed across the bridge into one of three kinds. A plain request has the lock line high one cycle after the start. A fresh locked attempt has the lock line high at the start and low one cycle later. A continuation has the lock line low at both points. For each request it forwards the transaction downstream, marked locked or unlocked, or it answers the primary side with a retry.

While a downstream lock is pending or held, the block drives the secondary lock line low, starting one clock after the forwarded address phase. A lock becomes established only when the forwarded transfer reports completion. It is dropped when the downstream target retries before that, or when the primary bus returns to idle with its lock line released. Requests arriving from the secondary side are passed upstream as plain transactions and never create lock state. A lock that a primary master holds on a primary-side target does not affect the block.

Top module: `xlock_tracker`

## Requirements
- R1: After a synchronous active-low reset, `sec_lock_drv_n` is 1 and `fwd_valid`, `fwd_locked`, `pri_retry`, `up_fwd` and `lock_held` are 0.
- R2: A fresh locked attempt aimed downstream, with command 4'h6 (memory read), no lock pending or held, and `sec_lock_n` high, is forwarded as locked. `fwd_valid` and `fwd_locked` are 1 in the cycle after the lock-assert cycle.
- R3: The block pulls `sec_lock_drv_n` low one clock after the cycle in which a locked forward is presented, and holds it low while the lock is pending or held.
- R4: A forwarded locked read leaves the lock pending (`lock_held`=0) until `xfer_done` is seen. `lock_held` is 1 in the cycle after `xfer_done`.
- R5: A fresh locked attempt made while a cross-bridge lock is pending or held gets `pri_retry`=1, is not forwarded, and leaves the existing lock unchanged.
- R6: A fresh locked attempt made while another master holds the secondary lock line (`sec_lock_n` low, `sec_lock_drv_n` high) gets `pri_retry`=1. No lock is recorded.
- R7: If `sec_retry` arrives while a lock is pending, the lock is dropped. `lock_held` stays 0 and `sec_lock_drv_n` returns to 1 two cycles later.
- R8: A fresh locked attempt whose command is not 4'h6 is forwarded unlocked (`fwd_locked`=0) and starts no lock.
- R9: While a lock is held, a continuation request aimed downstream with command 4'h6 or 4'h7 (memory write) is forwarded as locked.
- R10: While a lock is pending or held, `pri_idle`=1 together with `pri_lock_n`=1 releases it. `lock_held` is 0 in the next cycle and `sec_lock_drv_n` is 1 in the cycle after that.
- R11: A request started on the secondary side and aimed upstream produces `up_fwd`=1 one cycle later, whatever the value of `sec_lock_n`. It records no lock and does not drive the secondary lock line.
- R12: A locked request on the primary side that does not target the secondary side (`pri_to_sec`=0) is not forwarded, is not retried, and records no lock.
- R13: A plain request aimed downstream (lock line high one cycle after the start) is forwarded unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_start | input | 1 | Primary address-phase strobe |
| pri_lock_n | input | 1 | Primary lock line, active low |
| pri_idle | input | 1 | Primary bus is idle |
| pri_to_sec | input | 1 | Primary request decodes to the secondary side |
| pri_cmd | input | CMD_W | Primary command code |
| xfer_done | input | 1 | Forwarded transfer completed a data phase |
| sec_retry | input | 1 | Secondary target answered the forward with a retry |
| sec_start | input | 1 | Secondary address-phase strobe |
| sec_to_pri | input | 1 | Secondary request decodes to the primary side |
| sec_lock_n | input | 1 | Secondary lock line as observed, active low |
| fwd_valid | output | 1 | Forward the captured request downstream |
| fwd_locked | output | 1 | The forward carries the lock |
| pri_retry | output | 1 | Answer the primary request with a retry |
| sec_lock_drv_n | output | 1 | Secondary lock line drive, active low |
| up_fwd | output | 1 | Forward a secondary request upstream as plain |
| lock_held | output | 1 | Cross-bridge lock is established |

## Verification
The bench builds the block with its default parameters: a 4-bit command field, read code 4'h6 and write code 4'h7. These values let the directed tasks tell a locking read apart from a write and from an unrelated command. With them the tasks reach every path through the lock state machine: acquisition, establishment, continuation, release, retry for each of the two conflict causes, and a drop caused by a downstream retry.

// File: rtl/xlk_pkg.sv
// Shared types for the cross-bridge lock tracker.
// Assumes: two lock states beyond free; request kinds decided one cycle after the start.
package xlk_pkg;
    typedef enum logic [1:0] {
        XL_FREE = 2'd0,
        XL_PEND = 2'd1,
        XL_HELD = 2'd2
    } xl_state_t;

    typedef enum logic [1:0] {
        RQ_PLAIN = 2'd0,
        RQ_FRESH = 2'd1,
        RQ_CONT  = 2'd2
    } rq_kind_t;
endpackage

// File: rtl/xlk_req_stage.sv
// Captures a primary request at its address phase and classifies it one cycle
// later from the lock line. Assumes the lock line is sampled on both cycles.
module xlk_req_stage
    import xlk_pkg::*;
#(
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_start,
    input  logic             pri_lock_n,
    input  logic             pri_to_sec,
    input  logic [CMD_W-1:0] pri_cmd,
    output logic             rq_valid,
    output rq_kind_t         rq_kind,
    output logic [CMD_W-1:0] rq_cmd
);
    logic             st_valid;
    logic             st_lock_hi;
    logic             st_to_sec;
    logic [CMD_W-1:0] st_cmd;

    // Hold the address-phase view of the request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid   <= 1'b0;
            st_lock_hi <= 1'b1;
            st_to_sec  <= 1'b0;
            st_cmd     <= '0;
        end else begin
            st_valid   <= pri_start;
            st_lock_hi <= pri_lock_n;
            st_to_sec  <= pri_to_sec;
            st_cmd     <= pri_cmd;
        end
    end

    // Classify the request once the lock line has had its one-cycle delay.
    always_comb begin
        rq_valid = st_valid && st_to_sec;
        rq_cmd   = st_cmd;
        if (pri_lock_n)      rq_kind = RQ_PLAIN;
        else if (st_lock_hi) rq_kind = RQ_FRESH;
        else                 rq_kind = RQ_CONT;
    end
endmodule

// File: rtl/xlk_lock_fsm.sv
// Lock ownership state machine: grants, rejects, establishes and releases
// the cross-bridge lock. Assumes one classified request per cycle at most.
module xlk_lock_fsm
    import xlk_pkg::*;
#(
    parameter int               CMD_W = 4,
    parameter logic [CMD_W-1:0] RD    = 4'h6,
    parameter logic [CMD_W-1:0] WR    = 4'h7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rq_valid,
    input  rq_kind_t         rq_kind,
    input  logic [CMD_W-1:0] rq_cmd,
    input  logic             sec_other,
    input  logic             xfer_done,
    input  logic             sec_retry,
    input  logic             pri_idle,
    input  logic             pri_lock_n,
    output xl_state_t        state,
    output logic             fwd_valid,
    output logic             fwd_locked,
    output logic             pri_retry
);
    xl_state_t state_nx;
    logic      grant;
    logic      conflict;
    logic      cont_ok;
    logic      release_c;

    // Decide the fate of the current request.
    always_comb begin
        grant     = rq_valid && (rq_kind == RQ_FRESH) && (state == XL_FREE)
                    && !sec_other && (rq_cmd == RD);
        conflict  = rq_valid && (rq_kind == RQ_FRESH)
                    && ((state != XL_FREE) || sec_other);
        cont_ok   = rq_valid && (rq_kind == RQ_CONT) && (state == XL_HELD)
                    && ((rq_cmd == RD) || (rq_cmd == WR));
        release_c = pri_idle && pri_lock_n;
    end

    // Next-state selection for lock ownership.
    always_comb begin
        state_nx = state;
        if (grant) begin
            state_nx = XL_PEND;
        end else begin
            unique case (state)
                XL_PEND: begin
                    if (xfer_done)      state_nx = XL_HELD;
                    else if (sec_retry) state_nx = XL_FREE;
                    else if (release_c) state_nx = XL_FREE;
                end
                XL_HELD: if (release_c) state_nx = XL_FREE;
                default: state_nx = XL_FREE;
            endcase
        end
    end

    // Register state and the per-request response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= XL_FREE;
            fwd_valid  <= 1'b0;
            fwd_locked <= 1'b0;
            pri_retry  <= 1'b0;
        end else begin
            state      <= state_nx;
            fwd_valid  <= rq_valid && !conflict;
            fwd_locked <= grant || cont_ok;
            pri_retry  <= conflict;
        end
    end
endmodule

// File: rtl/xlk_sec_port.sv
// Secondary-side handling: drives the secondary lock line one cycle behind the
// lock state, detects a foreign secondary lock, and passes upstream requests
// through as plain transactions. Assumes sec_lock_n is the observed line.
module xlk_sec_port
    import xlk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  xl_state_t state,
    input  logic      sec_start,
    input  logic      sec_to_pri,
    input  logic      sec_lock_n,
    output logic      sec_lock_drv_n,
    output logic      sec_other,
    output logic      up_fwd
);
    // A low line that this block is not driving belongs to another master.
    always_comb begin
        sec_other = !sec_lock_n && sec_lock_drv_n;
    end

    // Lock drive trails the lock state by one clock; upstream pass-through pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_lock_drv_n <= 1'b1;
            up_fwd         <= 1'b0;
        end else begin
            sec_lock_drv_n <= (state == XL_FREE);
            up_fwd         <= sec_start && sec_to_pri;
        end
    end
endmodule

// File: rtl/xlock_tracker.sv
// Top of the cross-bridge lock tracker: request staging, lock state machine
// and secondary-side port. Assumes bus protocol, decode and buffering live
// outside and reach this block as single-bit flags.
module xlock_tracker
    import xlk_pkg::*;
#(
    parameter int               CMD_W       = 4,
    parameter logic [CMD_W-1:0] MEMRD_CODE  = 4'h6,
    parameter logic [CMD_W-1:0] MEMWR_CODE  = 4'h7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_start,
    input  logic             pri_lock_n,
    input  logic             pri_idle,
    input  logic             pri_to_sec,
    input  logic [CMD_W-1:0] pri_cmd,
    input  logic             xfer_done,
    input  logic             sec_retry,
    input  logic             sec_start,
    input  logic             sec_to_pri,
    input  logic             sec_lock_n,
    output logic             fwd_valid,
    output logic             fwd_locked,
    output logic             pri_retry,
    output logic             sec_lock_drv_n,
    output logic             up_fwd,
    output logic             lock_held
);
    logic             rq_valid;
    rq_kind_t         rq_kind;
    logic [CMD_W-1:0] rq_cmd;
    xl_state_t        state;
    logic             sec_other;

    xlk_req_stage #(.CMD_W(CMD_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_start  (pri_start),
        .pri_lock_n (pri_lock_n),
        .pri_to_sec (pri_to_sec),
        .pri_cmd    (pri_cmd),
        .rq_valid   (rq_valid),
        .rq_kind    (rq_kind),
        .rq_cmd     (rq_cmd)
    );

    xlk_lock_fsm #(.CMD_W(CMD_W), .RD(MEMRD_CODE), .WR(MEMWR_CODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rq_valid   (rq_valid),
        .rq_kind    (rq_kind),
        .rq_cmd     (rq_cmd),
        .sec_other  (sec_other),
        .xfer_done  (xfer_done),
        .sec_retry  (sec_retry),
        .pri_idle   (pri_idle),
        .pri_lock_n (pri_lock_n),
        .state      (state),
        .fwd_valid  (fwd_valid),
        .fwd_locked (fwd_locked),
        .pri_retry  (pri_retry)
    );

    xlk_sec_port u_sec (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .sec_start      (sec_start),
        .sec_to_pri     (sec_to_pri),
        .sec_lock_n     (sec_lock_n),
        .sec_lock_drv_n (sec_lock_drv_n),
        .sec_other      (sec_other),
        .up_fwd         (up_fwd)
    );

    // Established lock is visible as a single flag.
    always_comb begin
        lock_held = (state == XL_HELD);
    end
endmodule

// File: rtl/xlock_tracker_chk.sv
// Temporal checks on the lock tracker's ports, attached by bind.
module xlock_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_done,
    input logic fwd_valid,
    input logic fwd_locked,
    input logic pri_retry,
    input logic sec_lock_drv_n,
    input logic lock_held
);
    // R5
    retry_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_retry |-> !fwd_valid);

    // R2
    locked_needs_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_locked |-> fwd_valid);

    // R3
    drive_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_lock_drv_n) |-> $past(fwd_valid && fwd_locked));

    // R4
    held_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_held) |-> $past(xfer_done));

    // R3
    held_drives_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_held |-> !sec_lock_drv_n);
endmodule

bind xlock_tracker xlock_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_done      (xfer_done),
    .fwd_valid      (fwd_valid),
    .fwd_locked     (fwd_locked),
    .pri_retry      (pri_retry),
    .sec_lock_drv_n (sec_lock_drv_n),
    .lock_held      (lock_held)
);

// File: tb/xlock_tracker_bench.sv
module xlock_tracker_bench;
    localparam logic [3:0] RD = 4'h6;
    localparam logic [3:0] WR = 4'h7;
    localparam logic [3:0] IO = 4'h2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_start = 1'b0, pri_lock_n = 1'b1, pri_idle = 1'b1, pri_to_sec = 1'b0;
    logic [3:0] pri_cmd = 4'h0;
    logic xfer_done = 1'b0, sec_retry = 1'b0;
    logic sec_start = 1'b0, sec_to_pri = 1'b0, sec_lock_n = 1'b1;
    logic fwd_valid, fwd_locked, pri_retry, sec_lock_drv_n, up_fwd, lock_held;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xlock_tracker u_xlock_tracker (
        .clk(clk), .rst_n(rst_n),
        .pri_start(pri_start), .pri_lock_n(pri_lock_n), .pri_idle(pri_idle),
        .pri_to_sec(pri_to_sec), .pri_cmd(pri_cmd),
        .xfer_done(xfer_done), .sec_retry(sec_retry),
        .sec_start(sec_start), .sec_to_pri(sec_to_pri), .sec_lock_n(sec_lock_n),
        .fwd_valid(fwd_valid), .fwd_locked(fwd_locked), .pri_retry(pri_retry),
        .sec_lock_drv_n(sec_lock_drv_n), .up_fwd(up_fwd), .lock_held(lock_held)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pri_start = 1'b0; pri_lock_n = 1'b1; pri_idle = 1'b1; pri_to_sec = 1'b0;
        pri_cmd = 4'h0; xfer_done = 1'b0; sec_retry = 1'b0;
        sec_start = 1'b0; sec_to_pri = 1'b0; sec_lock_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Start at one negedge, lock line for the next cycle at the following one;
    // returns just after the decision edge.
    task automatic issue(input logic to_sec, input logic [3:0] cmd,
                         input logic lk_start, input logic lk_next);
        @(negedge clk);
        pri_start = 1'b1; pri_to_sec = to_sec; pri_cmd = cmd;
        pri_lock_n = lk_start; pri_idle = 1'b0;
        @(negedge clk);
        pri_start = 1'b0; pri_lock_n = lk_next;
        @(negedge clk);
    endtask

    // Acquire and establish a lock; leaves it held with the primary lock line low.
    task automatic acquire(input string tag);
        issue(1'b1, RD, 1'b1, 1'b0);
        chk({tag, " R2 fwd_valid"}, fwd_valid, 1'b1);
        chk({tag, " R2 fwd_locked"}, fwd_locked, 1'b1);
        chk({tag, " R4 pending not held"}, lock_held, 1'b0);
        @(negedge clk);
        chk({tag, " R3 drive low"}, sec_lock_drv_n, 1'b0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk({tag, " R4 held after done"}, lock_held, 1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 drv_n", sec_lock_drv_n, 1'b1);
        chk("R1 fwd_valid", fwd_valid, 1'b0);
        chk("R1 fwd_locked", fwd_locked, 1'b0);
        chk("R1 pri_retry", pri_retry, 1'b0);
        chk("R1 up_fwd", up_fwd, 1'b0);
        chk("R1 lock_held", lock_held, 1'b0);
    endtask

    task automatic t_acquire_release();
        do_reset();
        acquire("acq");
        @(negedge clk);
        chk("R3 drive held low", sec_lock_drv_n, 1'b0);
        pri_idle = 1'b1; pri_lock_n = 1'b1;
        @(negedge clk);
        chk("R10 released", lock_held, 1'b0);
        @(negedge clk);
        chk("R10 drive released", sec_lock_drv_n, 1'b1);
    endtask

    task automatic t_conflict_held();
        do_reset();
        acquire("cfl");
        issue(1'b1, RD, 1'b1, 1'b0);
        chk("R5 retry", pri_retry, 1'b1);
        chk("R5 not forwarded", fwd_valid, 1'b0);
        chk("R5 lock kept", lock_held, 1'b1);
    endtask

    task automatic t_conflict_pending();
        do_reset();
        issue(1'b1, RD, 1'b1, 1'b0);
        pri_lock_n = 1'b1;
        issue(1'b1, RD, 1'b1, 1'b0);
        chk("R5 retry while pending", pri_retry, 1'b1);
        chk("R5 pending not forwarded", fwd_valid, 1'b0);
    endtask

    task automatic t_foreign_sec();
        do_reset();
        sec_lock_n = 1'b0;
        issue(1'b1, RD, 1'b1, 1'b0);
        chk("R6 retry", pri_retry, 1'b1);
        chk("R6 not forwarded", fwd_valid, 1'b0);
        @(negedge clk);
        chk("R6 no drive", sec_lock_drv_n, 1'b1);
        chk("R6 no lock", lock_held, 1'b0);
    endtask

    task automatic t_sec_retry();
        do_reset();
        issue(1'b1, RD, 1'b1, 1'b0);
        @(negedge clk);
        sec_retry = 1'b1;
        @(negedge clk);
        sec_retry = 1'b0;
        chk("R7 no lock", lock_held, 1'b0);
        @(negedge clk);
        chk("R7 drive released", sec_lock_drv_n, 1'b1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R7 late done ignored", lock_held, 1'b0);
    endtask

    task automatic t_not_read();
        do_reset();
        issue(1'b1, WR, 1'b1, 1'b0);
        chk("R8 forwarded", fwd_valid, 1'b1);
        chk("R8 unlocked", fwd_locked, 1'b0);
        @(negedge clk);
        chk("R8 no drive", sec_lock_drv_n, 1'b1);
    endtask

    task automatic t_continue();
        do_reset();
        acquire("cont");
        issue(1'b1, WR, 1'b0, 1'b0);
        chk("R9 write fwd", fwd_valid, 1'b1);
        chk("R9 write locked", fwd_locked, 1'b1);
        issue(1'b1, IO, 1'b0, 1'b0);
        chk("R9 other cmd unlocked", fwd_locked, 1'b0);
    endtask

    task automatic t_upstream();
        do_reset();
        @(negedge clk);
        sec_start = 1'b1; sec_to_pri = 1'b1; sec_lock_n = 1'b0;
        @(negedge clk);
        sec_start = 1'b0;
        chk("R11 up_fwd", up_fwd, 1'b1);
        @(negedge clk);
        chk("R11 no lock", lock_held, 1'b0);
        chk("R11 no drive", sec_lock_drv_n, 1'b1);
    endtask

    task automatic t_local();
        do_reset();
        issue(1'b0, RD, 1'b1, 1'b0);
        chk("R12 not forwarded", fwd_valid, 1'b0);
        chk("R12 no retry", pri_retry, 1'b0);
        @(negedge clk);
        chk("R12 no drive", sec_lock_drv_n, 1'b1);
    endtask

    task automatic t_plain();
        do_reset();
        issue(1'b1, RD, 1'b1, 1'b1);
        chk("R13 forwarded", fwd_valid, 1'b1);
        chk("R13 unlocked", fwd_locked, 1'b0);
    endtask

    initial begin
        t_reset();
        t_acquire_release();
        t_conflict_held();
        t_conflict_pending();
        t_foreign_sec();
        t_sec_retry();
        t_not_read();
        t_continue();
        t_upstream();
        t_local();
        t_plain();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule